// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block sits between a synchronous host and an external 32K x 8 asynchronous static RAM. It has active-low select, output-enable and write-enable pins. The host hands over one request at a time: a read or write flag, a 15-bit address and, for writes, a byte. The controller turns that request into a sequence of pin phases. Each phase lasts a whole number of clock cycles, derived at elaboration time from nanosecond timing figures and the clock period. A phase length is ceil(ns / CLK_NS), with a floor of one cycle.

Writes are terminated by the write-enable strobe, with output-enable held high throughout. The controller drives the bidirectional data bus only while write-enable is low and during the hold phase that follows. After a read it leaves the bus alone until the memory's output float time has passed. Completion is reported by a one-cycle done pulse, and on reads the sampled byte comes with it. New requests are taken only while the controller reports ready.

Default figures (10 ns clock, 70 ns memory grade) give these phase lengths:
- write strobe WS = max(ceil(55), ceil(60), ceil(30)) / 10 = 6 cycles
- write hold WH = 1 cycle
- read strobe RS = max(ceil(35 / 10), ceil(70 / 10) - 1, ceil(70 / 10) - 1) = 6 cycles
- turnaround TT = ceil(25 / 10) = 3 cycles

Top module: `asram_ctrl`

## Requirements
- R1: While reset is applied, and after a synchronous reset, memCeN, memOeN and memWeN are all 1, reqReady is 1 and doneValid is 0.
- R2: A write is accepted on a clock edge where reqReady and reqValid are 1 and reqRead is 0. The sequence is one setup cycle (memCeN 0, memWeN 1), then WS cycles with memWeN 0, then WH hold cycles. doneValid is 1 in the cycle starting 1+WS+WH edges after the accepting edge (8 at defaults), and reqReady is 1 in that cycle.
- R3: A read is accepted with reqRead 1. The sequence is one setup cycle, then RS cycles with memOeN 0. The bus is sampled at the edge that ends the strobe. doneValid is 1, with the sampled byte on rdData, in the cycle starting 1+RS edges after the accepting edge (7 at defaults).
- R4: reqReady is 0 from the accepting edge until the controller is idle again. A request presented while reqReady is 0 is ignored, and memAddr does not change while reqReady is 0.
- R5: On every write, memWeN stays low at least T_WP ns. When memWeN rises, the address has been stable at least T_AW ns and the bus data at least T_DS ns, and memCeN is 0. memWeN falls only after a cycle with memCeN 0 and memWeN 1.
- R6: On every read, when memOeN rises, memOeN has been low at least T_OE ns and the address stable at least T_AA ns. memCeN stays low at least T_RC ns for a read and T_WC ns for a write, and the address does not change while memCeN is 0.
- R7: After a read's done pulse, reqReady returns TT cycles later (3 at defaults). The bus driver is not enabled until memOeN has been high for at least TT cycles, and the memory is never still driving when memWeN falls.
- R8: memOeN and memWeN are never both 0. memOeN is 1 whenever memWeN falls, and memWeN is 1 whenever memOeN falls.
- R9: The controller drives memData only while memCeN is 0 and memOeN is 1, and during the write strobe the bus carries the write byte.
- R10: doneValid is never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqRead | input | 1 | 1 = read, 0 = write |
| reqAddr | input | 15 | Request byte address |
| reqWdata | input | 8 | Write byte |
| reqReady | output | 1 | Controller idle, request will be taken |
| doneValid | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Byte sampled by the last read |
| memAddr | output | 15 | Memory address bus |
| memCeN | output | 1 | Memory select, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memData | inout | 8 | Bidirectional memory data bus |

## Verification
Isolated writes and reads are run at address zero, all ones and every single-bit address. They show whether each address line reaches the memory on its own, and whether the setup, strobe and hold lengths match the computed cycle counts. A strided sweep then alternates read, write and read-back on the same address. This separates read-to-write turnaround, which the float window and the contention check cover, from write-to-read ordering, which shows in the data read back. A request injected mid-write and back-to-back writes to one address show that a busy controller drops extra requests and that the last write wins. A timing memory model measures every strobe width and setup window in nanoseconds against the minimum figures.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_TURN   = 3'd4
  } seqState_t;

  // Strobes from sequencer to datapath: pin levels are registered,
  // load and capture are single-cycle enables.
  typedef struct packed {
    logic ceN;
    logic oeN;
    logic weN;
    logic drvEn;
    logic load;
    logic capture;
  } memCtl_t;

  function automatic int unsigned nsToCycles(input int unsigned ns, input int unsigned clkNs);
    int unsigned c;
    c = (ns + clkNs - 1) / clkNs;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Cycles left for a phase after crediting one setup cycle, never below one.
  function automatic int unsigned lessOne(input int unsigned c);
    return (c > 1) ? c - 1 : 1;
  endfunction

endpackage

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned CLK_NS = 10,
  parameter int unsigned T_WC   = 70,
  parameter int unsigned T_WP   = 55,
  parameter int unsigned T_AW   = 60,
  parameter int unsigned T_DS   = 30,
  parameter int unsigned T_DH   = 0,
  parameter int unsigned T_RC   = 70,
  parameter int unsigned T_AA   = 70,
  parameter int unsigned T_OE   = 35,
  parameter int unsigned T_OZ   = 25
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    reqRead,
  output logic    reqReady,
  output logic    doneValid,
  output memCtl_t ctl
);

  localparam int unsigned WR_STROBE = maxOf(maxOf(nsToCycles(T_WP, CLK_NS), nsToCycles(T_AW, CLK_NS)),
                                            nsToCycles(T_DS, CLK_NS));
  localparam int unsigned WC_CYC    = nsToCycles(T_WC, CLK_NS);
  localparam int unsigned WC_REST   = (WC_CYC > 1 + WR_STROBE) ? WC_CYC - 1 - WR_STROBE : 1;
  localparam int unsigned WR_HOLD   = maxOf(nsToCycles(T_DH, CLK_NS), WC_REST);
  localparam int unsigned RD_STROBE = maxOf(nsToCycles(T_OE, CLK_NS),
                                            maxOf(lessOne(nsToCycles(T_AA, CLK_NS)),
                                                  lessOne(nsToCycles(T_RC, CLK_NS))));
  localparam int unsigned TURN_CYC  = nsToCycles(T_OZ, CLK_NS);
  localparam int unsigned MAX_CYC   = maxOf(maxOf(WR_STROBE, WR_HOLD), maxOf(RD_STROBE, TURN_CYC));
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

  seqState_t stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic isReadQ, isReadD;
  logic doneQ, doneD;
  logic loadEn, captureEn;
  memCtl_t pinQ, pinD;

  function automatic memCtl_t pinsFor(input seqState_t s, input logic rd);
    memCtl_t p;
    p = '{ceN: 1'b1, oeN: 1'b1, weN: 1'b1, drvEn: 1'b0, load: 1'b0, capture: 1'b0};
    case (s)
      ST_SETUP:  p.ceN = 1'b0;
      ST_STROBE: begin
        p.ceN = 1'b0;
        if (rd) p.oeN = 1'b0;
        else begin
          p.weN   = 1'b0;
          p.drvEn = 1'b1;
        end
      end
      ST_HOLD: begin
        p.ceN   = 1'b0;
        p.drvEn = 1'b1;
      end
      default: ;
    endcase
    return p;
  endfunction

  always_comb begin
    stateD    = stateQ;
    cntD      = cntQ;
    isReadD   = isReadQ;
    doneD     = 1'b0;
    loadEn    = 1'b0;
    captureEn = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          loadEn  = 1'b1;
          isReadD = reqRead;
          stateD  = ST_SETUP;
        end
      end
      ST_SETUP: begin
        stateD = ST_STROBE;
        cntD   = isReadQ ? CNT_W'(RD_STROBE - 1) : CNT_W'(WR_STROBE - 1);
      end
      ST_STROBE: begin
        if (cntQ == '0) begin
          if (isReadQ) begin
            captureEn = 1'b1;
            doneD     = 1'b1;
            stateD    = ST_TURN;
            cntD      = CNT_W'(TURN_CYC - 1);
          end else begin
            stateD = ST_HOLD;
            cntD   = CNT_W'(WR_HOLD - 1);
          end
        end else begin
          cntD = cntQ - 1'b1;
        end
      end
      ST_HOLD: begin
        if (cntQ == '0) begin
          stateD = ST_IDLE;
          doneD  = 1'b1;
        end else begin
          cntD = cntQ - 1'b1;
        end
      end
      ST_TURN: begin
        if (cntQ == '0) stateD = ST_IDLE;
        else            cntD   = cntQ - 1'b1;
      end
      default: stateD = ST_IDLE;
    endcase
    pinD = pinsFor(stateD, isReadD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ  <= ST_IDLE;
      cntQ    <= '0;
      isReadQ <= 1'b0;
      doneQ   <= 1'b0;
      pinQ    <= pinsFor(ST_IDLE, 1'b0);
    end else begin
      stateQ  <= stateD;
      cntQ    <= cntD;
      isReadQ <= isReadD;
      doneQ   <= doneD;
      pinQ    <= pinD;
    end
  end

  assign reqReady  = (stateQ == ST_IDLE);
  assign doneValid = doneQ;
  assign ctl = '{ceN: pinQ.ceN, oeN: pinQ.oeN, weN: pinQ.weN, drvEn: pinQ.drvEn,
                 load: loadEn, capture: captureEn};

endmodule

// File: rtl/asram_datapath.sv
`timescale 1ns/1ps
module asram_datapath
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  memCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  inout  wire  [DATA_W-1:0] memData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wrDataQ;
  logic [DATA_W-1:0] rdDataQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ   <= '0;
      wrDataQ <= '0;
      rdDataQ <= '0;
    end else begin
      if (ctl.load) begin
        addrQ   <= reqAddr;
        wrDataQ <= reqWdata;
      end
      if (ctl.capture) rdDataQ <= memData;
    end
  end

  assign memAddr = addrQ;
  assign memCeN  = ctl.ceN;
  assign memOeN  = ctl.oeN;
  assign memWeN  = ctl.weN;
  assign rdData  = rdDataQ;
  assign memData = ctl.drvEn ? wrDataQ : {DATA_W{1'bz}};

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CLK_NS = 10,
  parameter int unsigned T_WC   = 70,
  parameter int unsigned T_WP   = 55,
  parameter int unsigned T_AW   = 60,
  parameter int unsigned T_DS   = 30,
  parameter int unsigned T_DH   = 0,
  parameter int unsigned T_RC   = 70,
  parameter int unsigned T_AA   = 70,
  parameter int unsigned T_OE   = 35,
  parameter int unsigned T_OZ   = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqRead,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              doneValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  inout  wire  [DATA_W-1:0] memData
);

  memCtl_t ctl;
  logic    drvEn;

  assign drvEn = ctl.drvEn;

  asram_seq #(
    .CLK_NS(CLK_NS), .T_WC(T_WC), .T_WP(T_WP), .T_AW(T_AW), .T_DS(T_DS),
    .T_DH(T_DH), .T_RC(T_RC), .T_AA(T_AA), .T_OE(T_OE), .T_OZ(T_OZ)
  ) i_seq (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .reqRead  (reqRead),
    .reqReady (reqReady),
    .doneValid(doneValid),
    .ctl      (ctl)
  );

  asram_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) i_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .rdData  (rdData),
    .memAddr (memAddr),
    .memCeN  (memCeN),
    .memOeN  (memOeN),
    .memWeN  (memWeN),
    .memData (memData)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned CLK_NS = 10,
  parameter int unsigned T_OZ   = 25
) (
  input logic              clk,
  input logic              rst,
  input logic              reqReady,
  input logic              doneValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memWeN,
  input logic              drvEn
);

  localparam int unsigned TURN_CYC = nsToCycles(T_OZ, CLK_NS);

  int unsigned oeHighCnt;

  always_ff @(posedge clk) begin
    if (rst)              oeHighCnt <= TURN_CYC;
    else if (!memOeN)     oeHighCnt <= 0;
    else if (oeHighCnt < TURN_CYC) oeHighCnt <= oeHighCnt + 1;
  end

  assert_idle_deselected_R1: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> (memCeN && memOeN && memWeN));

  assert_addr_held_busy_R4: assert property (@(posedge clk) disable iff (rst)
    !reqReady |=> $stable(memAddr));

  assert_we_after_setup_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(memWeN) |-> $past(!memCeN && memWeN));

  assert_float_wait_R7: assert property (@(posedge clk) disable iff (rst)
    drvEn |-> (oeHighCnt >= TURN_CYC));

  assert_no_oe_we_overlap_R8: assert property (@(posedge clk) disable iff (rst)
    !(!memOeN && !memWeN));

  assert_drive_when_selected_R9: assert property (@(posedge clk) disable iff (rst)
    drvEn |-> (!memCeN && memOeN));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    doneValid |=> !doneValid);

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W(ADDR_W), .CLK_NS(CLK_NS), .T_OZ(T_OZ)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .reqReady (reqReady),
  .doneValid(doneValid),
  .memAddr  (memAddr),
  .memCeN   (memCeN),
  .memOeN   (memOeN),
  .memWeN   (memWeN),
  .drvEn    (drvEn)
);

// File: tb/test_asram_ctrl.sv
`timescale 1ns/1ps
module test_asram_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int T_WC = 70, T_WP = 55, T_AW = 60, T_DS = 30, T_DH = 0;
  localparam int T_RC = 70, T_AA = 70, T_OE = 35, T_OZ = 25;
  localparam int DEPTH = 32768;
  localparam int WATCHDOG = 150000;

  function automatic int ceilCyc(input int ns);
    int c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Expected phase lengths from the requirement formulas.
  localparam int WS = mx(mx(ceilCyc(T_WP), ceilCyc(T_AW)), ceilCyc(T_DS));
  localparam int WH = mx(ceilCyc(T_DH), mx(ceilCyc(T_WC) - 1 - WS, 1));
  localparam int RS = mx(ceilCyc(T_OE), mx(mx(ceilCyc(T_AA) - 1, 1), mx(ceilCyc(T_RC) - 1, 1)));
  localparam int TT = ceilCyc(T_OZ);
  localparam int WR_LAT = 1 + WS + WH;
  localparam int RD_LAT = 1 + RS;

  logic        clk = 1'b0;
  logic        rst;
  logic        reqValid, reqRead;
  logic [14:0] reqAddr;
  logic [7:0]  reqWdata;
  logic        reqReady, doneValid;
  logic [7:0]  rdData;
  logic [14:0] memAddr;
  logic        memCeN, memOeN, memWeN;
  wire  [7:0]  memBus;

  int  total = 0;
  int  fails = 0;
  bit  armed = 1'b0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  asram_ctrl #(.CLK_NS(CLK_PERIOD)) i_asram_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqRead(reqRead),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .doneValid(doneValid), .rdData(rdData), .memAddr(memAddr),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN), .memData(memBus)
  );

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic [7:0] initByte(input int a);
    return 8'(a * 29 + 7) ^ 8'(a >> 7);
  endfunction
  function automatic logic [7:0] dataFor(input int a, input int k);
    return 8'(a * 53 + k * 17 + 3);
  endfunction

  // ---------------- behavioural memory model with timing checks ----------
  logic [7:0] modelMem [DEPTH];
  logic [7:0] refMem   [DEPTH];
  logic       floatHold = 1'b0;
  logic       lastWrite = 1'b0;
  longint     tAddr = 0, tBus = 0, tCeFall = 0, tWeFall = 0, tOeFall = 0;
  logic [7:0] modelOut;
  logic       modelDrive;

  assign modelOut   = modelMem[memAddr];
  assign modelDrive = (!memCeN && !memOeN && memWeN) || floatHold;
  assign memBus     = modelDrive ? modelOut : 8'bz;

  always @(memAddr) tAddr = $time;
  always @(memBus)  tBus  = $time;
  always @(negedge memCeN) tCeFall = $time;

  always @(posedge memCeN) if (armed) begin
    check(($time - tCeFall) >= (lastWrite ? T_WC : T_RC), "R6 select low time (ns)",
          $time - tCeFall, lastWrite ? T_WC : T_RC);
    check(tAddr <= tCeFall, "R6 address changed while selected (ns)", tAddr, tCeFall);
  end

  always @(negedge memWeN) if (armed) begin
    tWeFall   = $time;
    lastWrite = 1'b1;
    check(!floatHold, "R7 memory still driving at write strobe", floatHold, 0);
    check(memOeN == 1'b1, "R8 OE high at write strobe", memOeN, 1);
  end

  always @(posedge memWeN) if (armed) begin
    check(($time - tWeFall) >= T_WP, "R5 WE pulse width (ns)", $time - tWeFall, T_WP);
    check(($time - tAddr) >= T_AW, "R5 address setup to write end (ns)", $time - tAddr, T_AW);
    check(($time - tBus) >= T_DS, "R5 data setup to write end (ns)", $time - tBus, T_DS);
    check(memCeN == 1'b0, "R5 select low at write end", memCeN, 0);
    modelMem[memAddr] = memBus;
  end

  always @(negedge memOeN) if (armed) begin
    tOeFall   = $time;
    lastWrite = 1'b0;
    check(memWeN == 1'b1, "R8 WE high at read strobe", memWeN, 1);
  end

  always @(posedge memOeN) if (armed) begin
    check(($time - tOeFall) >= T_OE, "R6 OE low before sample (ns)", $time - tOeFall, T_OE);
    check(($time - tAddr) >= T_AA, "R6 address stable before sample (ns)", $time - tAddr, T_AA);
    floatHold = 1'b1;
    #(T_OZ);
    floatHold = 1'b0;
  end

  // ---------------- transaction tasks ----------------
  task automatic runWrite(input int a, input logic [7:0] d, input bit intrude, input int ia);
    int  n;
    bit  seen;
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqRead = 1'b0; reqAddr = 15'(a); reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    n = 1;
    seen = 1'b0;
    while (n < 40 && !seen) begin
      if (doneValid) seen = 1'b1;
      else begin
        if (n == 2) check(!reqReady, "R4 ready low during write", reqReady, 0);
        if (n == 3 && intrude) begin
          reqValid = 1'b1; reqRead = 1'b0; reqAddr = 15'(ia); reqWdata = ~d;
        end
        if (n == 4) begin
          check(memBus === d, "R9 bus carries write byte in strobe", memBus, d);
          if (intrude) reqValid = 1'b0;
        end
        @(negedge clk);
        n++;
      end
    end
    check(n == WR_LAT + 1, "R2 write done latency (negedges)", n, WR_LAT + 1);
    check(reqReady, "R2 ready with write done", reqReady, 1);
    refMem[a] = d;
    @(negedge clk);
    check(!doneValid, "R10 done is single cycle", doneValid, 0);
  endtask

  task automatic runRead(input int a);
    int n;
    int m;
    bit seen;
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqRead = 1'b1; reqAddr = 15'(a); reqWdata = 8'h00;
    @(negedge clk);
    reqValid = 1'b0;
    n = 1;
    seen = 1'b0;
    while (n < 40 && !seen) begin
      if (doneValid) seen = 1'b1;
      else begin
        if (n == 2) check(!reqReady, "R4 ready low during read", reqReady, 0);
        @(negedge clk);
        n++;
      end
    end
    check(n == RD_LAT + 1, "R3 read done latency (negedges)", n, RD_LAT + 1);
    check(rdData === refMem[a], "R3 read data", rdData, refMem[a]);
    m = 0;
    do begin
      @(negedge clk);
      m++;
      if (m == 1) check(!doneValid, "R10 done is single cycle", doneValid, 0);
    end while (!reqReady && m < 40);
    check(m == TT, "R7 turnaround cycles before ready", m, TT);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      modelMem[i] = initByte(i);
      refMem[i]   = initByte(i);
    end
    rst = 1'b1; reqValid = 1'b0; reqRead = 1'b0; reqAddr = '0; reqWdata = '0;
    repeat (4) @(negedge clk);
    check(memCeN && memOeN && memWeN, "R1 enables high in reset", {memCeN, memOeN, memWeN}, 7);
    rst = 1'b0;
    @(negedge clk);
    armed = 1'b1;
    check(memCeN && memOeN && memWeN, "R1 enables high after reset", {memCeN, memOeN, memWeN}, 7);
    check(reqReady, "R1 ready after reset", reqReady, 1);
    check(!doneValid, "R1 no done after reset", doneValid, 0);

    // Address-line walk: zero, all ones, each single bit.
    for (int b = -2; b < 15; b++) begin
      int a = (b == -2) ? 0 : (b == -1) ? 32767 : (1 << b);
      runWrite(a, dataFor(a, 1), 1'b0, 0);
    end
    for (int b = -2; b < 15; b++) begin
      int a = (b == -2) ? 0 : (b == -1) ? 32767 : (1 << b);
      runRead(a);
    end

    // Strided sweep: read old, write new, read back (read->write and write->read).
    for (int i = 0; i < 300; i++) begin
      int a = (i * 109 + 5) % DEPTH;
      runRead(a);
      runWrite(a, dataFor(a, i), 1'b0, 0);
      runRead(a);
    end

    // Request injected while busy must be dropped.
    runWrite(100, 8'h3C, 1'b1, 200);
    runRead(200);
    runRead(100);

    // Back-to-back writes to one address: last one wins.
    runWrite(4321, 8'h11, 1'b0, 0);
    runWrite(4321, 8'hEE, 1'b0, 0);
    runRead(4321);
    runWrite(4322, 8'h00, 1'b0, 0);
    runWrite(4322, 8'hFF, 1'b0, 0);
    runRead(4322);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog R2/R3 progress actual=%0d expected=%0d", WATCHDOG, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule